// File: doc/BRIEF.md
# Interrupt Status and Clear Register Bank

This block holds the interrupt state of a serial bus controller and exposes it to software through a small register port. Twelve event sources feed it. Ten of them are single-cycle event pulses that the bank latches until software clears them. Two of them, receive-full and transmit-empty, are live level conditions that are passed through and cannot be cleared. Software sees three views of this state: the unmasked raw status, a mask register, and the masked status. A single interrupt line is raised whenever any unmasked bit is set.

Clearing happens as a side effect of reading. Each latched source has its own clear address, so a handler can clear exactly the bits it has already seen. An event that arrives after the status read stays pending until it is serviced. A clear-all address is also provided for cases where losing late events does not matter. The bank also holds a 32-bit transmit-abort reason register. It collects the reason inputs whenever an abort is signalled and is wiped by the same read that clears the abort bit, so software must read it first.

Top module: `irq_status_bank`

## Requirements
- R1: After reset the mask register (0x30), the raw status (0x34) with both level inputs low, the masked status (0x2C), the abort-reason register (0x80) and the interrupt output are all zero.
- R2: Status bit positions are: 0 rx underflow, 1 rx overflow, 2 rx full, 3 tx overflow, 4 tx empty, 5 read request, 6 tx abort, 7 rx done, 8 activity, 9 stop seen, 10 start seen, 11 general call. A one-cycle pulse on event input bit i, for any i other than 2 or 4, sets raw status bit i from the next cycle on, and the bit stays set.
- R3: The mask register at 0x30 is written and read in bits 11:0. A read of 0x2C returns the raw status ANDed with the mask.
- R4: A read of address 0x44 + 4*k, for k = 0 to 9, clears only the latched bit from the list 0,1,3,5,6,7,8,9,10,11 at position k, and returns zero.
- R5: A read of 0x40 clears every latched bit that is set at that moment and returns zero. Level bits are left as they are.
- R6: When an event pulse and a clear read of the same bit fall in the same cycle, the bit ends up set.
- R7: Raw bits 2 and 4 follow the level inputs in the same cycle. Pulses on event bits 2 and 4 and all clear reads have no effect on them.
- R8: While the abort pulse (event bit 6) is high, the abort-reason input is ORed into the register at 0x80. A read of the abort clear address (0x54) or of 0x40 sets it to zero, except that a reason arriving in the same cycle is kept.
- R9: The interrupt output is high exactly when the masked status is non-zero.
- R10: Writes to any address other than 0x30 change nothing. Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regRdEn | input | 1 | Register read strobe (clear side effects apply at the clock edge) |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte address |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data, valid combinationally while regRdEn is high |
| evtPulse | input | 12 | Event pulses, one per status bit |
| lvlRxFull | input | 1 | Live receive-full condition |
| lvlTxEmpty | input | 1 | Live transmit-empty condition |
| abortReason | input | ABORT_W | Abort reason bits, sampled while the abort pulse is high |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench builds the bank with its default widths: an 8-bit address, 32-bit data and a 32-bit abort-reason register. At these widths the twelve-bit status space is small enough to sweep every one of the 4096 mask values against a fully set raw status, and every set of 4096 latched patterns against a full mask. Every individual clear address is applied to a fully set bank. The same-cycle set-and-clear race is driven on each of the ten latched bits.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int NUM_SRC   = 12;
  localparam int NUM_CLR   = 10;
  localparam int ABORT_BIT = 6;
  localparam int LVL_RXF   = 2;
  localparam int LVL_TXE   = 4;

  localparam logic [NUM_SRC-1:0] CLEARABLE =
    ~((NUM_SRC'(1) << LVL_RXF) | (NUM_SRC'(1) << LVL_TXE));

  localparam logic [7:0] OFF_MASKED  = 8'h2C;
  localparam logic [7:0] OFF_MASK    = 8'h30;
  localparam logic [7:0] OFF_RAW     = 8'h34;
  localparam logic [7:0] OFF_CLR_ALL = 8'h40;
  localparam logic [7:0] OFF_CLR0    = 8'h44;
  localparam logic [7:0] OFF_ABORT   = 8'h80;

  typedef enum logic [2:0] {
    RD_NONE, RD_MASKED, RD_MASK, RD_RAW, RD_ABORT
  } rdSel_e;

  typedef struct packed {
    logic [NUM_SRC-1:0] clrVec;
    logic               maskWe;
    logic               abortClr;
    rdSel_e             rdSel;
  } ctrlStrobe_t;

  // Status bit served by individual clear slot k (slot order is fixed by software).
  function automatic int clrBitOf(input int k);
    int idx;
    idx = 0;
    for (int b = 0; b < NUM_SRC; b++) begin
      if (CLEARABLE[b]) begin
        if (idx == k) return b;
        idx++;
      end
    end
    return 0;
  endfunction
endpackage

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regRdEn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobe_t       strb
);
  localparam int SLOT_STEP = 4;

  logic [NUM_CLR-1:0] slotHit;
  logic               clrAllHit;

  genvar k;
  generate
    for (k = 0; k < NUM_CLR; k++) begin : gSlot
      assign slotHit[k] = regRdEn &&
        (regAddr == ADDR_W'(OFF_CLR0) + ADDR_W'(k * SLOT_STEP));
    end
  endgenerate

  assign clrAllHit = regRdEn && (regAddr == ADDR_W'(OFF_CLR_ALL));

  always_comb begin
    strb = '0;
    strb.rdSel = RD_NONE;
    if (clrAllHit) strb.clrVec = CLEARABLE;
    for (int s = 0; s < NUM_CLR; s++) begin
      if (slotHit[s]) strb.clrVec[clrBitOf(s)] = 1'b1;
    end
    strb.abortClr = strb.clrVec[ABORT_BIT];
    strb.maskWe   = regWrEn && (regAddr == ADDR_W'(OFF_MASK));
    if (regRdEn) begin
      if (regAddr == ADDR_W'(OFF_MASKED))     strb.rdSel = RD_MASKED;
      else if (regAddr == ADDR_W'(OFF_MASK))  strb.rdSel = RD_MASK;
      else if (regAddr == ADDR_W'(OFF_RAW))   strb.rdSel = RD_RAW;
      else if (regAddr == ADDR_W'(OFF_ABORT)) strb.rdSel = RD_ABORT;
    end
  end

  // R4: an individual clear address never strobes more than one bit
  assert_single_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdEn && regAddr != ADDR_W'(OFF_CLR_ALL)) |-> ($countones(strb.clrVec) <= 1));

  // R10: only the mask address produces a write strobe
  assert_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && regAddr != ADDR_W'(OFF_MASK)) |-> !strb.maskWe);
endmodule

// File: rtl/irq_bank_data.sv
module irq_bank_data
  import irq_bank_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ABORT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStrobe_t        strb,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic               lvlRxFull,
  input  logic               lvlTxEmpty,
  input  logic [ABORT_W-1:0] abortReason,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irqOut
);
  logic [NUM_SRC-1:0] latched, latchedNext;
  logic [NUM_SRC-1:0] maskReg;
  logic [NUM_SRC-1:0] rawStat, maskedStat;
  logic [ABORT_W-1:0] abortSrc, abortNext;

  always_comb begin
    latchedNext = ((latched & ~strb.clrVec) | evtPulse) & CLEARABLE;
    abortNext   = (strb.abortClr ? '0 : abortSrc) |
                  (evtPulse[ABORT_BIT] ? abortReason : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched  <= '0;
      maskReg  <= '0;
      abortSrc <= '0;
    end else begin
      latched  <= latchedNext;
      abortSrc <= abortNext;
      if (strb.maskWe) maskReg <= regWrData[NUM_SRC-1:0];
    end
  end

  always_comb begin
    rawStat          = latched;
    rawStat[LVL_RXF] = lvlRxFull;
    rawStat[LVL_TXE] = lvlTxEmpty;
    maskedStat       = rawStat & maskReg;
  end

  assign irqOut = |maskedStat;

  always_comb begin
    regRdData = '0;
    case (strb.rdSel)
      RD_MASKED: regRdData = DATA_W'(maskedStat);
      RD_MASK:   regRdData = DATA_W'(maskReg);
      RD_RAW:    regRdData = DATA_W'(rawStat);
      RD_ABORT:  regRdData = DATA_W'(abortSrc);
      default:   regRdData = '0;
    endcase
  end

  genvar i;
  generate
    for (i = 0; i < NUM_SRC; i++) begin : gChk
      if (CLEARABLE[i]) begin : gClr
        // R6: an event pulse always leaves its bit set, even against a clear
        assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
          evtPulse[i] |=> latched[i]);
        // R4: a clear strobe without a competing pulse empties the bit
        assert_clear_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
          (strb.clrVec[i] && !evtPulse[i]) |=> !latched[i]);
      end
    end
  endgenerate

  // R8: the abort clear wipes the reason register unless a new reason arrives
  assert_abort_wipe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.abortClr && !evtPulse[ABORT_BIT]) |=> (abortSrc == '0));

  // R9: with a zero mask the interrupt line stays low
  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (maskReg == '0) |-> !irqOut);

  // R7: level bits track their inputs regardless of clears
  assert_level_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdData[LVL_RXF] == lvlRxFull) || (strb.rdSel != RD_RAW));
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int ABORT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               regRdEn,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic               lvlRxFull,
  input  logic               lvlTxEmpty,
  input  logic [ABORT_W-1:0] abortReason,
  output logic               irqOut
);
  ctrlStrobe_t strb;

  irq_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .regRdEn (regRdEn),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  irq_bank_data #(.DATA_W(DATA_W), .ABORT_W(ABORT_W)) u_data (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .regWrData   (regWrData),
    .evtPulse    (evtPulse),
    .lvlRxFull   (lvlRxFull),
    .lvlTxEmpty  (lvlTxEmpty),
    .abortReason (abortReason),
    .regRdData   (regRdData),
    .irqOut      (irqOut)
  );
endmodule

// File: tb/sim_irq_status_bank.sv
module sim_irq_status_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regRdEn = 1'b0, regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic [11:0] evtPulse = '0;
  logic        lvlRxFull = 1'b0, lvlTxEmpty = 1'b0;
  logic [31:0] abortReason = '0;
  logic        irqOut;

  int nChecks = 0, nFails = 0;
  int slotBit [10] = '{0, 1, 3, 5, 6, 7, 8, 9, 10, 11};
  logic [11:0] mdlLatched = '0;
  logic [11:0] mdlMask = '0;

  always #4 clk = ~clk;

  irq_status_bank u0 (
    .clk(clk), .rst_n(rst_n), .regRdEn(regRdEn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .evtPulse(evtPulse), .lvlRxFull(lvlRxFull), .lvlTxEmpty(lvlTxEmpty),
    .abortReason(abortReason), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] rawExp();
    logic [11:0] r;
    r = mdlLatched;
    r[2] = lvlRxFull;
    r[4] = lvlTxEmpty;
    return r;
  endfunction

  // read with optional simultaneous pulse; returns data seen before the edge
  task automatic rdOp(input logic [7:0] a, input logic [11:0] p, input logic [31:0] rsn,
                      output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a; evtPulse = p; abortReason = rsn;
    #1 d = regRdData;
    @(posedge clk);
    #1 regRdEn = 1'b0; evtPulse = '0; abortReason = '0;
  endtask

  task automatic rdChk(input logic [7:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    rdOp(a, '0, '0, d);
    check(req, d, exp);
  endtask

  task automatic wrOp(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = v;
    @(posedge clk);
    #1 regWrEn = 1'b0;
  endtask

  task automatic pulse(input logic [11:0] p, input logic [31:0] rsn);
    @(negedge clk);
    evtPulse = p; abortReason = rsn;
    @(posedge clk);
    #1 evtPulse = '0; abortReason = '0;
    mdlLatched = mdlLatched | (p & 12'hFEB);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rdChk(8'h30, 32'h0, "R1 mask");
    rdChk(8'h34, 32'h0, "R1 raw");
    rdChk(8'h2C, 32'h0, "R1 masked");
    rdChk(8'h80, 32'h0, "R1 abort");
    check("R1 irq", {31'b0, irqOut}, 32'h0);

    // R7 level bits: follow inputs, immune to pulses and clears
    pulse(12'h014, 32'h0);
    rdChk(8'h34, 32'h0, "R7 pulse on level bit ignored");
    lvlRxFull = 1'b1;
    rdChk(8'h34, 32'h004, "R7 rx full level");
    lvlTxEmpty = 1'b1;
    rdChk(8'h40, 32'h0, "R5 clear-all returns 0");
    rdChk(8'h34, 32'h014, "R7 levels survive clear-all");
    lvlRxFull = 1'b0; lvlTxEmpty = 1'b0;
    rdChk(8'h34, 32'h0, "R7 levels drop");

    // R2 and R4 per-bit set and clear
    for (int k = 0; k < 10; k++) begin
      pulse(12'(1) << slotBit[k], 32'h0);
      rdChk(8'h34, 32'(12'(1) << slotBit[k]), "R2 bit latched");
      rdChk(8'h34, 32'(12'(1) << slotBit[k]), "R2 bit holds");
      rdChk(8'h44 + 8'(4 * k), 32'h0, "R4 clear returns 0");
      mdlLatched = '0;
      rdChk(8'h34, 32'h0, "R4 bit cleared");
    end

    // R4 exhaustive: each clear on a full bank removes only its bit
    pulse(12'hFFF, 32'h0);
    for (int k = 0; k < 10; k++) begin
      rdChk(8'h44 + 8'(4 * k), 32'h0, "R4 clear returns 0");
      mdlLatched[slotBit[k]] = 1'b0;
      rdChk(8'h34, 32'(rawExp()), "R4 only target bit cleared");
    end
    rdChk(8'h80, 32'h0, "R8 abort wiped by its clear");

    // R3 / R9 mask sweep over full raw status
    pulse(12'hFEB, 32'h0);
    lvlRxFull = 1'b1; lvlTxEmpty = 1'b1;
    for (int m = 0; m < 4096; m++) begin
      wrOp(8'h30, 32'hFFFF_F000 | 32'(m));
      mdlMask = 12'(m);
      rdOp(8'h2C, '0, '0, d);
      check("R3 masked = raw & mask", d, 32'(rawExp() & mdlMask));
      check("R9 irq", {31'b0, irqOut}, {31'b0, |(rawExp() & mdlMask)});
    end
    rdChk(8'h30, 32'hFFF, "R3 mask readback");

    // R3 / R9 latched-pattern sweep under full mask
    lvlRxFull = 1'b0; lvlTxEmpty = 1'b0;
    for (int p = 0; p < 4096; p++) begin
      rdChk(8'h40, 32'h0, "R5 clear-all returns 0");
      mdlLatched = '0;
      pulse(12'(p), 32'h0);
      rdOp(8'h2C, '0, '0, d);
      check("R3 masked pattern", d, 32'(rawExp()));
      check("R9 irq pattern", {31'b0, irqOut}, {31'b0, rawExp() != 0});
    end

    // R5 clear-all on a full bank
    pulse(12'hFFF, 32'h0);
    rdChk(8'h40, 32'h0, "R5 clear-all returns 0");
    mdlLatched = '0;
    rdChk(8'h34, 32'h0, "R5 all latched cleared");
    check("R9 irq low after clear", {31'b0, irqOut}, 32'h0);

    // R6 set wins against an individual clear and against clear-all
    for (int k = 0; k < 10; k++) begin
      rdOp(8'h44 + 8'(4 * k), 12'(1) << slotBit[k], 32'h0, d);
      mdlLatched = 12'(1) << slotBit[k];
      rdChk(8'h34, 32'(mdlLatched), "R6 set wins over clear");
      rdChk(8'h40, 32'h0, "R5 clear-all returns 0");
      mdlLatched = '0;
    end
    pulse(12'h003, 32'h0);
    rdOp(8'h40, 12'h800, 32'h0, d);
    mdlLatched = 12'h800;
    rdChk(8'h34, 32'h800, "R6 set wins over clear-all");
    rdChk(8'h40, 32'h0, "R5 clear-all returns 0");
    mdlLatched = '0;

    // R8 abort reason collection and wipe
    pulse(12'h040, 32'h0000_00A5);
    pulse(12'h040, 32'h1200_0000);
    rdChk(8'h80, 32'h1200_00A5, "R8 reasons accumulate");
    pulse(12'h000, 32'hFFFF_0000);
    rdChk(8'h80, 32'h1200_00A5, "R8 reason ignored without pulse");
    rdChk(8'h54, 32'h0, "R8 abort clear returns 0");
    rdChk(8'h80, 32'h0, "R8 abort clear wipes reason");
    pulse(12'h040, 32'h0000_0F00);
    rdOp(8'h54, 12'h040, 32'h0003_0000, d);
    rdChk(8'h80, 32'h0003_0000, "R8 same-cycle reason kept");
    rdChk(8'h40, 32'h0, "R5 clear-all returns 0");
    rdChk(8'h80, 32'h0, "R8 clear-all wipes reason");
    mdlLatched = '0;

    // R10 writes elsewhere ignored, unmapped reads zero
    wrOp(8'h30, 32'h0000_0AAA);
    pulse(12'h0C1, 32'h0000_0007);
    wrOp(8'h34, 32'hFFFF_FFFF);
    wrOp(8'h2C, 32'h0);
    wrOp(8'h44, 32'hFFFF_FFFF);
    wrOp(8'h40, 32'hFFFF_FFFF);
    wrOp(8'h80, 32'h0);
    rdChk(8'h34, 32'h0C1, "R10 raw unchanged by writes");
    rdChk(8'h30, 32'hAAA, "R10 mask unchanged by writes");
    rdChk(8'h80, 32'h7, "R10 abort unchanged by writes");
    rdChk(8'h38, 32'h0, "R10 unmapped read zero");
    rdChk(8'h6C, 32'h0, "R10 unmapped read zero");
    rdChk(8'h34, 32'h0C1, "R10 unmapped read clears nothing");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule